// File: doc/BRIEF.md
# Coherence Miss Handling Controller

This block is the state machine for one cache line in a snooping, acknowledgement-counting coherence protocol. It covers the full read-miss path and a write-allocate miss. When the processor loads from a line that is not present, the controller allocates the line, opens a miss-tracking entry and sends a shared-read request to the home node. It then waits for the data message and hands the data to the processor as soon as it arrives. After that it keeps counting acknowledgements from the peer caches, and the line becomes stable only once the last one is in.

A processor store that misses issues an exclusive-read request instead. While the miss is open, the line accepts no processor loads or stores: the request port drops its ready signal and the request waits at the port. Acknowledgements that arrive before the data go into the same counter, so none are lost. Peer read and write requests that arrive during a miss are legal inputs and do not change the state. If no acknowledging peer reports a copy, a completed read miss ends in exclusive rather than shared.

Top module: `coh_miss_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 0), no tracking entry is valid, `cpu_req_ready` is 1, and `home_req_valid` and `cpu_rsp_valid` are 0.
- R2: A load accepted while the line is invalid (or misses the resident address) produces, in the next cycle, a one-cycle `home_req_valid` pulse with `home_req_excl`=0 and the load address, line state read-wait (code 1), and `tbe_valid`=1.
- R3: A data message (`msg_kind`=0) in read-wait produces `cpu_rsp_valid` with that message's data in the next cycle. If acknowledgements are still missing, the line moves to read-acks (code 2).
- R4: In read-acks the line holds its state until NPEERS acknowledgements (`msg_kind`=1) in total have arrived for this miss. In the cycle after the last one, the line is stable and `tbe_valid` is 0 in that same cycle.
- R5: A completed read miss ends in shared (code 3) if any acknowledgement carried `msg_sharer`=1, otherwise in exclusive (code 4).
- R6: Acknowledgements received before the data are counted. If all NPEERS arrive before the data, the data message moves the line straight to its stable state in the same step that returns the data.
- R7: Peer read (`msg_kind`=2) and peer write (`msg_kind`=3) messages during a miss leave the state, the counter and the outputs unchanged.
- R8: A store accepted in the invalid state sends a request with `home_req_excl`=1 and enters write-wait (code 5). Data with acks still missing moves the line to write-acks (code 6). Once both the data and all NPEERS acks are in, the line becomes modified (code 7), and a response carrying the store data is given in that cycle.
- R9: While `tbe_valid` is 1, `cpu_req_ready` is 0, and a presented processor request causes no home request and no response.
- R10: A load to the resident address in shared, exclusive or modified state is answered in the next cycle with the line data and sends no home request.
- R11: A store to the resident address in modified state updates the line data and is answered in the next cycle without a home request. A later load returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Line address of the request |
| cpu_req_wdata | input | DW | Store data (full line) |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_rsp_valid | output | 1 | Response pulse to the processor |
| cpu_rsp_data | output | DW | Response data |
| home_req_valid | output | 1 | Request pulse to the home node |
| home_req_excl | output | 1 | 1 = exclusive read, 0 = shared read |
| home_req_addr | output | AW | Address of the miss being requested |
| msg_valid | input | 1 | Incoming message present |
| msg_kind | input | 2 | 0 data, 1 ack, 2 peer read, 3 peer write |
| msg_data | input | DW | Data payload of a data message |
| msg_sharer | input | 1 | On an ack: the sender keeps a copy |
| line_state | output | 3 | Current line state code |
| tbe_valid | output | 1 | Miss-tracking entry in use |

## Verification
The read miss is driven with acks split around the data, with every ack before the data, and with acks mixed with peer requests. Together these separate a counter that loses early acks from one that keeps them, and a direct jump to the stable state from a pass through read-acks. Runs with and without a sharer flag on one ack tell shared apart from exclusive. Store misses are run with the data first and with the data last, which checks both exits into modified. Hits and stalled requests show that no home request leaks out while an entry is open.

// File: rtl/coh_miss_pkg.sv
package coh_miss_pkg;

  typedef enum logic [2:0] {
    LS_INV      = 3'd0,
    LS_RD_WAIT  = 3'd1,
    LS_RD_ACKS  = 3'd2,
    LS_SHARED   = 3'd3,
    LS_EXCL     = 3'd4,
    LS_WR_WAIT  = 3'd5,
    LS_WR_ACKS  = 3'd6,
    LS_MOD      = 3'd7
  } line_state_e;

  typedef enum logic [1:0] {
    MK_DATA    = 2'd0,
    MK_ACK     = 2'd1,
    MK_PEER_RD = 2'd2,
    MK_PEER_WR = 2'd3
  } msg_kind_e;

  // one counting step, saturating at the number of peers
  function automatic int unsigned ack_step(int unsigned cur, logic ack, int unsigned limit);
    return (ack && cur < limit) ? cur + 1 : cur;
  endfunction

  function automatic logic is_stable(line_state_e s);
    return (s == LS_SHARED) || (s == LS_EXCL) || (s == LS_MOD);
  endfunction

  // stable state reached by a completed read miss
  function automatic line_state_e read_fill_state(logic any_sharer);
    return any_sharer ? LS_SHARED : LS_EXCL;
  endfunction

endpackage

// File: rtl/coh_ack_counter.sv
module coh_ack_counter #(
  parameter int unsigned NPEERS = 3,
  parameter int unsigned CW     = $clog2(NPEERS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          ack_in,
  input  logic          sharer_in,
  output logic [CW-1:0] count,
  output logic          done_next,
  output logic          sharer_next
);
  import coh_miss_pkg::*;

  localparam logic [CW-1:0] LIMIT = CW'(NPEERS);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          shr_q;

  always_comb begin
    cnt_nx      = CW'(ack_step(32'(cnt_q), ack_in, NPEERS));
    done_next   = (cnt_nx == LIMIT);
    sharer_next = shr_q | (ack_in & sharer_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
      shr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      shr_q <= sharer_next;
    end
  end

  assign count = cnt_q;

  AST_ACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R4

  AST_ACK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/coh_miss_tracker.sv
module coh_miss_tracker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_addr,
  input  logic          alloc_store,
  input  logic [DW-1:0] alloc_wdata,
  input  logic          free,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic          store,
  output logic [DW-1:0] wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      store <= 1'b0;
      wdata <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      addr  <= alloc_addr;
      store <= alloc_store;
      wdata <= alloc_wdata;
    end else if (free) begin
      valid <= 1'b0;
    end
  end

  AST_NO_DOUBLE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid); // R9

  AST_FREE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    free |-> valid); // R4

endmodule

// File: rtl/coh_line_fsm.sv
module coh_line_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_fire,
  input  logic                      req_store,
  input  logic                      tag_hit,
  input  logic                      data_in,
  input  logic                      ack_done_next,
  input  logic                      sharer_next,
  output coh_miss_pkg::line_state_e state,
  output logic                      ev_alloc,
  output logic                      ev_rd_data,
  output logic                      ev_complete,
  output logic                      ev_load_hit,
  output logic                      ev_store_hit
);
  import coh_miss_pkg::*;

  line_state_e state_q, state_nx;

  always_comb begin
    ev_load_hit  = req_fire && !req_store && tag_hit && is_stable(state_q);
    ev_store_hit = req_fire && req_store && tag_hit && (state_q == LS_MOD);
    ev_alloc     = req_fire && !ev_load_hit && !ev_store_hit;
    ev_rd_data   = (state_q == LS_RD_WAIT) && data_in;
    ev_complete  = 1'b0;
    state_nx     = state_q;
    case (state_q)
      LS_RD_WAIT: begin
        if (data_in) begin
          if (ack_done_next) begin
            state_nx    = read_fill_state(sharer_next);
            ev_complete = 1'b1;
          end else begin
            state_nx = LS_RD_ACKS;
          end
        end
      end
      LS_RD_ACKS: begin
        if (ack_done_next) begin
          state_nx    = read_fill_state(sharer_next);
          ev_complete = 1'b1;
        end
      end
      LS_WR_WAIT: begin
        if (data_in) begin
          if (ack_done_next) begin
            state_nx    = LS_MOD;
            ev_complete = 1'b1;
          end else begin
            state_nx = LS_WR_ACKS;
          end
        end
      end
      LS_WR_ACKS: begin
        if (ack_done_next) begin
          state_nx    = LS_MOD;
          ev_complete = 1'b1;
        end
      end
      default: begin
        if (ev_alloc) state_nx = req_store ? LS_WR_WAIT : LS_RD_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LS_INV;
    else        state_q <= state_nx;
  end

  assign state = state_q;

  AST_RD_ACKS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_RD_ACKS && !ack_done_next) |=> (state_q == LS_RD_ACKS)); // R4

  AST_COMPLETE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> is_stable(state_q)); // R4

  AST_WR_ENDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_WR_ACKS && ack_done_next) |=> (state_q == LS_MOD)); // R8

endmodule

// File: rtl/coh_miss_ctrl.sv
module coh_miss_ctrl #(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned NPEERS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_store,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_req_ready,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_data,
  output logic          home_req_valid,
  output logic          home_req_excl,
  output logic [AW-1:0] home_req_addr,
  input  logic          msg_valid,
  input  logic [1:0]    msg_kind,
  input  logic [DW-1:0] msg_data,
  input  logic          msg_sharer,
  output logic [2:0]    line_state,
  output logic          tbe_valid
);
  import coh_miss_pkg::*;

  localparam int unsigned CW = $clog2(NPEERS + 1);

  // internal events, named for the assertions
  logic          req_fire, tag_hit, data_in, ack_in, peer_in;
  logic          ev_alloc, ev_rd_data, ev_complete, ev_load_hit, ev_store_hit;
  logic          ack_done_next, sharer_next;
  logic [CW-1:0] ack_count;
  logic          tbe_store;
  logic [DW-1:0] tbe_wdata;
  line_state_e   state;
  logic [AW-1:0] line_addr;
  logic [DW-1:0] line_data;

  assign cpu_req_ready = !tbe_valid;
  assign req_fire      = cpu_req_valid && cpu_req_ready;
  assign tag_hit       = (line_addr == cpu_req_addr);
  assign data_in       = msg_valid && tbe_valid && (msg_kind == MK_DATA);
  assign ack_in        = msg_valid && tbe_valid && (msg_kind == MK_ACK);
  assign peer_in       = msg_valid && ((msg_kind == MK_PEER_RD) || (msg_kind == MK_PEER_WR));

  coh_line_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .req_store    (cpu_req_store),
    .tag_hit      (tag_hit),
    .data_in      (data_in),
    .ack_done_next(ack_done_next),
    .sharer_next  (sharer_next),
    .state        (state),
    .ev_alloc     (ev_alloc),
    .ev_rd_data   (ev_rd_data),
    .ev_complete  (ev_complete),
    .ev_load_hit  (ev_load_hit),
    .ev_store_hit (ev_store_hit)
  );

  coh_ack_counter #(.NPEERS(NPEERS), .CW(CW)) u_acks (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ev_alloc),
    .ack_in     (ack_in),
    .sharer_in  (msg_sharer),
    .count      (ack_count),
    .done_next  (ack_done_next),
    .sharer_next(sharer_next)
  );

  coh_miss_tracker #(.AW(AW), .DW(DW)) u_tbe (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (ev_alloc),
    .alloc_addr (cpu_req_addr),
    .alloc_store(cpu_req_store),
    .alloc_wdata(cpu_req_wdata),
    .free       (ev_complete),
    .valid      (tbe_valid),
    .addr       (home_req_addr),
    .store      (tbe_store),
    .wdata      (tbe_wdata)
  );

  // line storage and registered outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_addr      <= '0;
      line_data      <= '0;
      cpu_rsp_valid  <= 1'b0;
      cpu_rsp_data   <= '0;
      home_req_valid <= 1'b0;
      home_req_excl  <= 1'b0;
    end else begin
      home_req_valid <= ev_alloc;
      if (ev_alloc) begin
        line_addr     <= cpu_req_addr;
        home_req_excl <= cpu_req_store;
      end
      if (ev_rd_data)                 line_data <= msg_data;
      else if (ev_complete && tbe_store) line_data <= tbe_wdata;
      else if (ev_store_hit)          line_data <= cpu_req_wdata;
      cpu_rsp_valid <= ev_rd_data || ev_load_hit || ev_store_hit || (ev_complete && tbe_store);
      if (ev_rd_data)        cpu_rsp_data <= msg_data;
      else if (ev_load_hit)  cpu_rsp_data <= line_data;
      else if (ev_store_hit) cpu_rsp_data <= cpu_req_wdata;
      else if (ev_complete)  cpu_rsp_data <= tbe_wdata;
    end
  end

  assign line_state = state;

  AST_ALLOC_SENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> (home_req_valid && home_req_excl == $past(cpu_req_store))); // R2

  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tbe_valid && cpu_req_valid) |=> !home_req_valid); // R9

  AST_FREE_WITH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tbe_valid) |-> is_stable(state)); // R4

  AST_READ_DATA_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_RD_WAIT && data_in) |=> (cpu_rsp_valid && cpu_rsp_data == $past(msg_data))); // R3

  AST_PEER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_in && state == LS_RD_WAIT) |=> (state == LS_RD_WAIT && !cpu_rsp_valid && $stable(ack_count))); // R7

endmodule

// File: tb/test_coh_miss_ctrl.sv
module test_coh_miss_ctrl;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned NPEERS = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_store;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_data;
  logic          home_req_valid, home_req_excl;
  logic [AW-1:0] home_req_addr;
  logic          msg_valid, msg_sharer;
  logic [1:0]    msg_kind;
  logic [DW-1:0] msg_data;
  logic [2:0]    line_state;
  logic          tbe_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  coh_miss_ctrl #(.AW(AW), .DW(DW), .NPEERS(NPEERS)) i_coh_miss_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    cpu_req_valid = 1'b1; cpu_req_store = st; cpu_req_addr = a; cpu_req_wdata = wd;
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
  endtask

  task automatic msg(input logic [1:0] k, input logic [DW-1:0] d, input logic s);
    msg_valid = 1'b1; msg_kind = k; msg_data = d; msg_sharer = s;
    @(posedge clk); #1;
    msg_valid = 1'b0; msg_sharer = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", 32'(line_state), 0);
    chk("R1 tbe", 32'(tbe_valid), 0);
    chk("R1 ready", 32'(cpu_req_ready), 1);
    chk("R1 home", 32'(home_req_valid), 0);
    chk("R1 rsp", 32'(cpu_rsp_valid), 0);
  endtask

  // read miss, acks after data, one sharer, peer traffic, stalled request
  task automatic t_read_shared();
    cpu(1'b0, 16'h0100, '0);
    chk("R2 home", 32'(home_req_valid), 1);
    chk("R2 excl", 32'(home_req_excl), 0);
    chk("R2 addr", 32'(home_req_addr), 32'h0100);
    chk("R2 state", 32'(line_state), 1);
    chk("R2 tbe", 32'(tbe_valid), 1);
    @(posedge clk); #1;
    chk("R2 pulse", 32'(home_req_valid), 0);
    msg(2'd2, 32'hDEAD, 1'b0);
    chk("R7 peer rd state", 32'(line_state), 1);
    chk("R7 peer rd rsp", 32'(cpu_rsp_valid), 0);
    msg(2'd0, 32'hA5A5_0001, 1'b0);
    chk("R3 rsp", 32'(cpu_rsp_valid), 1);
    chk("R3 data", cpu_rsp_data, 32'hA5A5_0001);
    chk("R3 state", 32'(line_state), 2);
    msg(2'd3, 32'hBEEF, 1'b0);
    chk("R7 peer wr state", 32'(line_state), 2);
    cpu_req_valid = 1'b1; cpu_req_store = 1'b0; cpu_req_addr = 16'h0200; #1;
    chk("R9 ready low", 32'(cpu_req_ready), 0);
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
    chk("R9 no home", 32'(home_req_valid), 0);
    chk("R9 no rsp", 32'(cpu_rsp_valid), 0);
    msg(2'd1, '0, 1'b0);
    chk("R4 hold1", 32'(line_state), 2);
    msg(2'd1, '0, 1'b1);
    chk("R4 hold2", 32'(line_state), 2);
    chk("R4 tbe held", 32'(tbe_valid), 1);
    msg(2'd1, '0, 1'b0);
    chk("R5 shared", 32'(line_state), 3);
    chk("R4 tbe freed", 32'(tbe_valid), 0);
    chk("R4 ready", 32'(cpu_req_ready), 1);
    cpu(1'b0, 16'h0100, '0);
    chk("R10 rsp", 32'(cpu_rsp_valid), 1);
    chk("R10 data", cpu_rsp_data, 32'hA5A5_0001);
    chk("R10 no home", 32'(home_req_valid), 0);
  endtask

  // acks split around data, no sharers -> exclusive
  task automatic t_read_excl_split();
    cpu(1'b0, 16'h0300, '0);
    chk("R2 miss on mismatch", 32'(home_req_valid), 1);
    msg(2'd1, '0, 1'b0);
    msg(2'd1, '0, 1'b0);
    chk("R6 early acks wait", 32'(line_state), 1);
    msg(2'd0, 32'h1234_5678, 1'b0);
    chk("R6 to acks", 32'(line_state), 2);
    chk("R3 data", cpu_rsp_data, 32'h1234_5678);
    msg(2'd1, '0, 1'b0);
    chk("R5 excl", 32'(line_state), 4);
    chk("R4 freed", 32'(tbe_valid), 0);
  endtask

  // all acks before data -> direct to stable
  task automatic t_read_all_early();
    cpu(1'b0, 16'h0400, '0);
    for (int i = 0; i < NPEERS; i++) msg(2'd1, '0, 1'b0);
    chk("R6 still wait", 32'(line_state), 1);
    msg(2'd0, 32'h0BAD_F00D, 1'b0);
    chk("R6 direct excl", 32'(line_state), 4);
    chk("R6 rsp", 32'(cpu_rsp_valid), 1);
    chk("R6 data", cpu_rsp_data, 32'h0BAD_F00D);
    chk("R6 freed", 32'(tbe_valid), 0);
  endtask

  // store misses, then store and load hits
  task automatic t_store();
    cpu(1'b1, 16'h0500, 32'hCAFE_0001);
    chk("R8 excl", 32'(home_req_excl), 1);
    chk("R8 home", 32'(home_req_valid), 1);
    chk("R8 state", 32'(line_state), 5);
    for (int i = 0; i < NPEERS; i++) msg(2'd1, '0, 1'b1);
    chk("R8 wait data", 32'(line_state), 5);
    msg(2'd0, 32'h5555_5555, 1'b0);
    chk("R8 mod", 32'(line_state), 7);
    chk("R8 rsp", 32'(cpu_rsp_valid), 1);
    chk("R8 rsp data", cpu_rsp_data, 32'hCAFE_0001);
    chk("R8 freed", 32'(tbe_valid), 0);
    cpu(1'b0, 16'h0500, '0);
    chk("R11 load after store miss", cpu_rsp_data, 32'hCAFE_0001);
    cpu(1'b1, 16'h0500, 32'hCAFE_0002);
    chk("R11 store hit rsp", 32'(cpu_rsp_valid), 1);
    chk("R11 no home", 32'(home_req_valid), 0);
    chk("R11 still mod", 32'(line_state), 7);
    cpu(1'b0, 16'h0500, '0);
    chk("R11 load new", cpu_rsp_data, 32'hCAFE_0002);
    cpu(1'b1, 16'h0600, 32'hCAFE_0003);
    msg(2'd0, 32'h0, 1'b0);
    chk("R8 data first", 32'(line_state), 6);
    msg(2'd1, '0, 1'b0);
    msg(2'd1, '0, 1'b0);
    chk("R8 acks pending", 32'(line_state), 6);
    msg(2'd1, '0, 1'b0);
    chk("R8 mod late", 32'(line_state), 7);
    chk("R8 late rsp", cpu_rsp_data, 32'hCAFE_0003);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_store = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    msg_valid = 1'b0; msg_kind = '0; msg_data = '0; msg_sharer = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_read_shared();
    t_read_excl_split();
    t_read_all_early();
    t_store();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule